// File: doc/BRIEF.md
# Safety Fault Collection Unit

This block gathers the internal fault lines of a safety controller: lockstep compare mismatch, uncorrectable memory error, clock monitor, voltage monitor and the like. Each line gets its own reaction from a small configuration port. Faults are brought into the unit's own clock domain by two-flop synchronizers and latched as sticky flags. The unit then steers the device toward a safe state by itself, with no processor involved. It reports health on a pair of external pins that carry complementary levels while all is well.

The unit runs from its own free-running clock, so the alarm timeout stays deterministic when other clocks fail. After reset it first runs a self-test. In that self-test it drives a walking-one pattern through its reaction decoder under a built-in default configuration, first with the alarm reaction and then with the fatal reaction. Any mismatch forces the terminal failure state. Once the self-test passes, it starts normal monitoring. A fault with the alarm reaction opens a time window. If software clears the flag within that window, the unit returns to normal. If not, it escalates to the failure state.

Top module: `fault_collector`

## Requirements
- R1: After reset release the unit stays in self-test for exactly 2*N_FAULTS clock cycles, with err_p_o=1 and err_n_o=1 and all flags zero. It then enters normal operation with err_p_o=0 and err_n_o=1.
- R2: A fault whose reaction code is 00 sets no flag and changes neither alarm_o nor the error pins.
- R3: A fault with reaction code 01 sets its flag, and the error pins stay at the healthy encoding (err_p_o=0, err_n_o=1).
- R4: A fault input with reaction 10 that is sampled high at edge k sets its flag at edge k+2, through two synchronizer flops and the flag register. alarm_o then rises at edge k+3.
- R5: If the alarm state is entered at edge E and its flag is not cleared, the unit enters the failure state at edge E+T+1, where T is the timeout register. In the failure state err_p_o=0, err_n_o=0 and alarm_o=0.
- R6: Clearing every flag that has reaction 10 while in the alarm state returns the unit to normal one edge after the clear takes effect.
- R7: A flagged fault with reaction code 11 moves the unit straight to the failure state and sets reset_req_o. reset_req_o is never high outside the failure state, and it stays low when failure came from an alarm timeout.
- R8: Flags are sticky until written clear. A clear request for a fault whose synchronized input is still high is refused.
- R9: The failure state is left only through reset. Writes to the clear register do not restore the healthy pin encoding.
- R10: Register map (cfg_addr_i). Address 0 holds the reaction codes, with fault k in bits 2k+1:2k; the reset value is 10 for every fault. Address 1 clears flag k when either bit of lane 2k+1:2k is set. Address 2 holds the timeout T, with reset value DEF_TMO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Independent unit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_i | input | N_FAULTS | Raw fault lines, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 2*N_FAULTS | Configuration write data |
| err_p_o | output | 1 | Error pin, positive leg |
| err_n_o | output | 1 | Error pin, negative leg |
| alarm_o | output | 1 | High while the alarm window is open |
| reset_req_o | output | 1 | Reset request after a fatal fault |
| flags_o | output | N_FAULTS | Sticky fault flags |

## Verification
The hardest situation to reach from the ports is the alarm window. Its timing has to be pinned to exact edges: the synchronizer delay, the entry into alarm and the escalation edge all depend on when the fault was sampled. The directed sequence shortens the timeout to 3 through the configuration port. It then drives a fault a half cycle before an edge and samples on the edges just before and just after each predicted transition. Constrained random rounds mix all four reaction codes across random fault vectors, each round starting from reset. The attempt to clear a flag while its input is held high is driven directly.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef logic [1:0] rx_t;
  localparam rx_t RX_IGNORE = 2'b00;
  localparam rx_t RX_FLAG   = 2'b01;
  localparam rx_t RX_ALARM  = 2'b10;
  localparam rx_t RX_FATAL  = 2'b11;

  typedef enum logic [1:0] {
    ST_SELF  = 2'd0,
    ST_NORM  = 2'd1,
    ST_ALARM = 2'd2,
    ST_FAULT = 2'd3
  } fc_state_e;

  localparam logic [1:0] A_RX  = 2'd0;
  localparam logic [1:0] A_CLR = 2'd1;
  localparam logic [1:0] A_TMO = 2'd2;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fc_classify.sv
module fc_classify
  import fc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         [N-1:0] vec_i,
  input  rx_t          [N-1:0] rx_i,
  output logic         [N-1:0] en_o,
  output logic         [N-1:0] alarm_o,
  output logic         [N-1:0] fatal_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    assign en_o[k]    = (rx_i[k] != RX_IGNORE);
    assign alarm_o[k] = vec_i[k] && (rx_i[k] == RX_ALARM);
    assign fatal_o[k] = vec_i[k] && (rx_i[k] == RX_FATAL);
  end
endmodule

// File: rtl/fc_flags.sv
module fc_flags #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] set_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  // set wins; clear refused while the line is still high
  assign flag_d = (flag_q & ~(clr_i & ~sync_i)) | (sync_i & set_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & sync_i) != '0) |=> ((flag_q & $past(flag_q & sync_i)) == $past(flag_q & sync_i)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~flag_q & ~(sync_i & set_en_i)) != '0) |=> ((flag_q & $past(~flag_q & ~(sync_i & set_en_i))) == '0));
endmodule

// File: rtl/fc_selftest.sv
module fc_selftest
  import fc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic [N-1:0] alarm_i,
  input  logic [N-1:0] fatal_i,
  output logic [N-1:0] pattern_o,
  output rx_t  [N-1:0] rx_o,
  output logic         done_o,
  output logic         fail_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] idx_q;
  logic             pass_q;
  logic [N-1:0]     exp_alarm, exp_fatal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pass_q <= 1'b0;
    end else if (active_i) begin
      if (idx_q == LAST) begin
        idx_q  <= '0;
        pass_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign pattern_o = N'(1) << idx_q;
  assign exp_alarm = pass_q ? '0 : pattern_o;
  assign exp_fatal = pass_q ? pattern_o : '0;

  for (genvar k = 0; k < N; k++) begin : g_cfg
    assign rx_o[k] = pass_q ? RX_FATAL : RX_ALARM;
  end

  assign done_o = active_i && pass_q && (idx_q == LAST);
  assign fail_o = active_i && ((alarm_i != exp_alarm) || (fatal_i != exp_fatal));

  // R1
  selftest_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> !fail_o);
endmodule

// File: rtl/fault_collector.sv
module fault_collector
  import fc_pkg::*;
#(
  parameter int N_FAULTS = 8,
  parameter int DEF_TMO  = 100,
  localparam int DATA_W  = 2 * N_FAULTS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_FAULTS-1:0] fault_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic                err_p_o,
  output logic                err_n_o,
  output logic                alarm_o,
  output logic                reset_req_o,
  output logic [N_FAULTS-1:0] flags_o
);
  localparam int N = N_FAULTS;

  fc_state_e       state_q, state_d;
  rx_t     [N-1:0] rx_q, cls_rx, st_rx;
  logic [DATA_W-1:0] tmo_q, tmr_q;
  logic [N-1:0]    sync, flags, cls_vec, en_v, alarm_v, fatal_v, pattern, clr_v;
  logic            self_act, st_done, st_fail, alarm_any, fatal_any, req_q;

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) rx_q[k] <= RX_ALARM;
      tmo_q <= DATA_W'(DEF_TMO);
    end else if (cfg_we_i) begin
      if (cfg_addr_i == A_RX)  rx_q  <= cfg_wdata_i;
      if (cfg_addr_i == A_TMO) tmo_q <= cfg_wdata_i;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_clr
    assign clr_v[k] = cfg_we_i && (cfg_addr_i == A_CLR) && (|cfg_wdata_i[2*k+1:2*k]);
  end

  fc_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fault_i),
    .q_o   (sync)
  );

  assign self_act = (state_q == ST_SELF);
  assign cls_vec  = self_act ? pattern : flags;
  assign cls_rx   = self_act ? st_rx : rx_q;

  fc_classify #(.N(N)) u_cls (
    .vec_i  (cls_vec),
    .rx_i   (cls_rx),
    .en_o   (en_v),
    .alarm_o(alarm_v),
    .fatal_o(fatal_v)
  );

  fc_flags #(.N(N)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync),
    .set_en_i(en_v & {N{!self_act}}),
    .clr_i   (clr_v),
    .flag_o  (flags)
  );

  fc_selftest #(.N(N)) u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (self_act),
    .alarm_i  (alarm_v),
    .fatal_i  (fatal_v),
    .pattern_o(pattern),
    .rx_o     (st_rx),
    .done_o   (st_done),
    .fail_o   (st_fail)
  );

  assign alarm_any = !self_act && (|alarm_v);
  assign fatal_any = !self_act && (|fatal_v);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SELF:  if (st_fail) state_d = ST_FAULT;
                else if (st_done) state_d = ST_NORM;
      ST_NORM:  if (fatal_any) state_d = ST_FAULT;
                else if (alarm_any) state_d = ST_ALARM;
      ST_ALARM: if (fatal_any) state_d = ST_FAULT;
                else if (!alarm_any) state_d = ST_NORM;
                else if (tmr_q >= tmo_q) state_d = ST_FAULT;
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SELF;
      tmr_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= (state_q == ST_ALARM && state_d == ST_ALARM) ? tmr_q + 1'b1 : '0;
      if ((state_q == ST_NORM || state_q == ST_ALARM) && fatal_any) req_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SELF:  {err_p_o, err_n_o} = 2'b11;
      ST_FAULT: {err_p_o, err_n_o} = 2'b00;
      default:  {err_p_o, err_n_o} = 2'b01;
    endcase
  end

  assign alarm_o     = (state_q == ST_ALARM);
  assign reset_req_o = req_q;
  assign flags_o     = flags;

  // R9
  fault_terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT) |=> (state_q == ST_FAULT));

  // R7
  req_in_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (state_q == ST_FAULT));

  // R5
  tmr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALARM) |-> (tmr_q <= tmo_q));

  // R1
  self_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SELF) |-> (flags == '0));

  // R6
  alarm_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALARM && !alarm_any && !fatal_any) |=> (state_q == ST_NORM));
endmodule

// File: tb/fault_collector_bench.sv
`timescale 1ns/1ps
module fault_collector_bench;
  localparam int N  = 8;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  fault = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          err_p, err_n, alarm, req;
  logic [N-1:0]  flags;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  fault_collector #(.N_FAULTS(N), .DEF_TMO(100)) u_fault_collector (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fault_i    (fault),
    .cfg_we_i   (we),
    .cfg_addr_i (addr),
    .cfg_wdata_i(wdata),
    .err_p_o    (err_p),
    .err_n_o    (err_n),
    .alarm_o    (alarm),
    .reset_req_o(req),
    .flags_o    (flags)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic do_reset(input bit check);
    fault = '0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2 * N - 1);
    if (check) begin
      chk("R1 pins in self-test", {err_p, err_n}, 2'b11);
      chk("R1 flags in self-test", flags, 0);
    end
    tick(1);
    if (check) chk("R1 pins after self-test", {err_p, err_n}, 2'b01);
  endtask

  function automatic logic [N-1:0] exp_flags(input logic [DW-1:0] rx, input logic [N-1:0] f);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = f[k] && (rx[2*k +: 2] != 2'b00);
    return r;
  endfunction

  function automatic logic [1:0] exp_cls(input logic [DW-1:0] rx, input logic [N-1:0] f);
    logic a, x;
    a = 1'b0; x = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (f[k] && rx[2*k +: 2] == 2'b10) a = 1'b1;
      if (f[k] && rx[2*k +: 2] == 2'b11) x = 1'b1;
    end
    return {x, a};
  endfunction

  initial begin
    void'($urandom(32'h5A17));
    do_reset(1'b1);

    // R10 map: fault0=00, fault1=01, others 10
    wr(2'd0, 16'hAAA4);
    fault = 8'h01;
    tick(5);
    chk("R2 flag for ignored fault", flags, 0);
    chk("R2 alarm for ignored fault", alarm, 0);
    chk("R2 pins for ignored fault", {err_p, err_n}, 2'b01);
    fault = 8'h02;
    tick(5);
    chk("R3 flag-only sets flag", flags, 8'h02);
    chk("R3 pins stay healthy", {err_p, err_n, alarm}, 3'b010);
    wr(2'd1, 16'h0004);
    tick(1);
    chk("R8 clear refused while asserted", flags, 8'h02);
    fault = '0;
    tick(3);
    chk("R8 flag sticky after input drops", flags, 8'h02);
    wr(2'd1, 16'h0008);
    chk("R8 clear after input drop", flags, 0);

    // R4 latency, then R6 clear-back
    fault = 8'h04;
    tick(3);
    chk("R4 flag at k+2", flags, 8'h04);
    chk("R4 no alarm yet at k+2", alarm, 0);
    tick(1);
    chk("R4 alarm at k+3", alarm, 1);
    fault = '0;
    tick(4);
    wr(2'd1, 16'h0030);
    chk("R6 flag cleared", flags, 0);
    chk("R6 still alarm on clear edge", alarm, 1);
    tick(1);
    chk("R6 back to normal", {alarm, err_p, err_n}, 3'b001);

    // R5 timeout escalation with T=3
    wr(2'd2, 16'd3);
    fault = 8'h08;
    tick(4);
    chk("R5 alarm entered", alarm, 1);
    tick(3);
    chk("R5 still alarm at E+T", {alarm, err_p, err_n}, 3'b101);
    tick(1);
    chk("R5 failure at E+T+1", {alarm, err_p, err_n}, 3'b000);
    chk("R7 no reset request on timeout", req, 0);
    fault = '0;
    tick(3);
    wr(2'd1, 16'hFFFF);
    tick(3);
    chk("R9 failure survives clear", {err_p, err_n}, 2'b00);

    // R7 fatal reaction
    do_reset(1'b1);
    wr(2'd0, 16'hABAA);
    fault = 8'h10;
    tick(3);
    chk("R7 healthy before decision", {err_p, err_n, req}, 3'b010);
    tick(1);
    chk("R7 fatal to failure", {err_p, err_n}, 2'b00);
    chk("R7 reset request", req, 1);
    fault = '0;

    // random rounds
    for (int r = 0; r < 16; r++) begin
      logic [DW-1:0] rx;
      logic [N-1:0]  f;
      logic [1:0]    c;
      do_reset(1'b0);
      rx = DW'($urandom);
      f  = N'($urandom);
      wr(2'd0, rx);
      fault = f;
      tick(5);
      c = exp_cls(rx, f);
      chk("R3 random flags", flags, exp_flags(rx, f));
      if (c[1]) begin
        chk("R7 random fatal", {err_p, err_n, req, alarm}, 4'b0010);
      end else if (c[0]) begin
        chk("R4 random alarm", {err_p, err_n, req, alarm}, 4'b0101);
      end else begin
        chk("R2 random quiet", {err_p, err_n, req, alarm}, 4'b0100);
      end
      fault = '0;
      tick(2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule